// File: doc/BRIEF.md
# Type-C CC Line Classifier

This block sequences the measurement of a Type-C port's two configuration-channel pins (CC1 and CC2) and reports what each pin sees. The termination is reported as open, Ra or Rd when the port pulls the lines up, or as one of three advertised source currents when the port pulls them down. The analog front end (pull resistors, threshold DAC, comparator, level detector) sits outside. The block only drives the pin-select and pull-up-select switches and the DAC code, waits a settle time, and samples the front end's answers.

Acting as source, each measured pin is checked twice at most. It is first compared against the no-connect threshold; a high comparator means open. Otherwise a second comparison against the Rd threshold separates Rd (high) from Ra (low). With VCONN enabled, only the pin named by the polarity input is measured, and the other pin's result is kept. Acting as sink, both pins are measured in turn and the 2-bit level code is decoded. Once the run ends, the pin-select switches go back to the setting that was in force when the run began. A one-cycle done pulse marks the point where both results are valid.

Top module: `cc_classifier`

## Requirements
- R1: While reset is asserted and right after it, both results read open (code 0), done is low, dac_code is 0 and meas_sel and pu_sel are 0.
- R2: In source role, one cycle after start is accepted, meas_sel and pu_sel select the first pin one-hot (bit 0 is CC1, bit 1 is CC2) and dac_code equals thr_open. The comparator is sampled SETTLE_CYC cycles later, and a high value gives open (code 0) for that pin.
- R3: In source role, if the first comparison is low, dac_code changes to thr_rd for another SETTLE_CYC cycles. A high comparator then gives Rd (code 2) and a low one gives Ra (code 1).
- R4: In source role with vconn_on low, CC1 is measured first and then CC2.
- R5: In source role with vconn_on high, only CC2 is measured when polarity is 1, and only CC1 when polarity is 0. The result of the other pin is unchanged.
- R6: In sink role, CC1 and then CC2 are measured, each for SETTLE_CYC cycles, with pu_sel held at 0 and dac_code at 0. Level 0 gives open (0), level 1 gives default current (3), level 2 gives 1.5 A (4) and level 3 gives 3.0 A (5).
- R7: While idle, meas_sel follows idle_sel one cycle later. In the done cycle, meas_sel equals the idle_sel value captured when start was accepted, and pu_sel is 0.
- R8: done is high for exactly one cycle. It appears T+1 rising edges after the start edge, counting the start edge, where T is the sum of SETTLE_CYC for each first comparison plus SETTLE_CYC for each second comparison (sink role: 2*SETTLE_CYC).
- R9: A start pulse during a run is ignored: the run keeps the role, VCONN flag, polarity and thresholds it began with, and its latency does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement run (taken only when idle) |
| src_role | input | 1 | 1 = port pulls up (source), 0 = pulls down (sink) |
| vconn_on | input | 1 | VCONN is being supplied on the non-CC pin |
| polarity | input | 1 | 0 = CC1 carries communication, 1 = CC2 |
| thr_open | input | DW | DAC code for the no-connect comparison |
| thr_rd | input | DW | DAC code for the Rd/Ra comparison |
| idle_sel | input | 2 | Pin-select setting in force outside a run |
| comp_hi | input | 1 | Comparator: selected pin above the DAC level |
| level | input | 2 | Sink-side level code of the selected pin |
| meas_sel | output | 2 | Pin-select switches, bit 0 = CC1, bit 1 = CC2 |
| pu_sel | output | 2 | Pull-up switch on the measured pin (source role) |
| dac_code | output | DW | Threshold DAC code |
| cc1_res | output | 3 | CC1 classification |
| cc2_res | output | 3 | CC2 classification |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
The select and DAC outputs are due one edge after the start edge, and the second-step DAC code one edge after the first sample. The done pulse and both results are due T+1 edges after the start edge, where T depends on which pins are measured and whether each pin needed a second comparison. The bench computes T from its pin model before each run, counts rising edges, and reads every output at the falling edge after the edge where the value is due. The restored select value is checked in the done cycle, and its return to following idle_sel is checked one cycle later.

// File: rtl/cc_cls_pkg.sv
package cc_cls_pkg;

    typedef enum logic [2:0] {
        CC_OPEN   = 3'd0,
        CC_RA     = 3'd1,
        CC_RD     = 3'd2,
        CC_RP_DEF = 3'd3,
        CC_RP_1A5 = 3'd4,
        CC_RP_3A0 = 3'd5
    } cc_res_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } cc_st_e;

    function automatic logic [1:0] pin_hot(input logic pin);
        return pin ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/cc_settle_timer.sv
module cc_settle_timer #(
    parameter int unsigned SETTLE_CYC = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expire
);
    localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (arm) begin
            tm_d.run = 1'b1;
            tm_d.cnt = '0;
        end else if (tm_q.run) begin
            if (tm_q.cnt == LAST) tm_d.run = 1'b0;
            else                  tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expire = tm_q.run && (tm_q.cnt == LAST);

    // Settle window never runs past its last count.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.run |-> (tm_q.cnt <= LAST));

    // An expiry without a new arm stops the counter.
    assert_stop_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !arm) |=> !tm_q.run);

endmodule

// File: rtl/cc_level_decode.sv
module cc_level_decode
    import cc_cls_pkg::*;
(
    input  logic       sink_mode,
    input  logic       second_step,
    input  logic       comp,
    input  logic [1:0] level,
    output cc_res_e    res,
    output logic       open_seen
);
    always_comb begin
        open_seen = 1'b0;
        res       = CC_OPEN;
        if (sink_mode) begin
            unique case (level)
                2'd0: res = CC_OPEN;
                2'd1: res = CC_RP_DEF;
                2'd2: res = CC_RP_1A5;
                default: res = CC_RP_3A0;
            endcase
        end else if (!second_step) begin
            open_seen = comp;
            res       = CC_OPEN;
        end else begin
            res = comp ? CC_RD : CC_RA;
        end
    end
endmodule

// File: rtl/cc_classifier.sv
module cc_classifier
    import cc_cls_pkg::*;
#(
    parameter int unsigned DW         = 6,
    parameter int unsigned SETTLE_CYC = 62500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          src_role,
    input  logic          vconn_on,
    input  logic          polarity,
    input  logic [DW-1:0] thr_open,
    input  logic [DW-1:0] thr_rd,
    input  logic [1:0]    idle_sel,
    input  logic          comp_hi,
    input  logic [1:0]    level,
    output logic [1:0]    meas_sel,
    output logic [1:0]    pu_sel,
    output logic [DW-1:0] dac_code,
    output logic [2:0]    cc1_res,
    output logic [2:0]    cc2_res,
    output logic          done
);

    typedef struct packed {
        cc_st_e        st;
        logic          pin;
        logic          src;
        logic          vconn;
        logic          pol;
        logic [DW-1:0] thr_open;
        logic [DW-1:0] thr_rd;
        logic [1:0]    saved;
        logic [1:0]    meas_sel;
        logic [1:0]    pu_sel;
        logic [DW-1:0] dac;
        cc_res_e       res1;
        cc_res_e       res2;
        logic          done;
    } cls_t;

    cls_t    cls_d, cls_q;
    logic    arm, store, expire, open_seen;
    cc_res_e dec_res;

    cc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .expire (expire)
    );

    cc_level_decode u_dec (
        .sink_mode   (!cls_q.src),
        .second_step (cls_q.st == ST_SECOND),
        .comp        (comp_hi),
        .level       (level),
        .res         (dec_res),
        .open_seen   (open_seen)
    );

    always_comb begin
        cls_d      = cls_q;
        cls_d.done = 1'b0;
        arm        = 1'b0;
        store      = 1'b0;
        unique case (cls_q.st)
            ST_IDLE: begin
                cls_d.meas_sel = idle_sel;
                cls_d.pu_sel   = 2'b00;
                if (start) begin
                    cls_d.src      = src_role;
                    cls_d.vconn    = vconn_on;
                    cls_d.pol      = polarity;
                    cls_d.thr_open = thr_open;
                    cls_d.thr_rd   = thr_rd;
                    cls_d.saved    = idle_sel;
                    cls_d.pin      = (src_role && vconn_on) ? polarity : 1'b0;
                    cls_d.st       = ST_FIRST;
                    cls_d.meas_sel = pin_hot(cls_d.pin);
                    cls_d.pu_sel   = src_role ? pin_hot(cls_d.pin) : 2'b00;
                    cls_d.dac      = src_role ? thr_open : '0;
                    arm            = 1'b1;
                end
            end
            ST_FIRST: begin
                if (expire) begin
                    if (cls_q.src && !open_seen) begin
                        cls_d.dac = cls_q.thr_rd;
                        cls_d.st  = ST_SECOND;
                        arm       = 1'b1;
                    end else begin
                        store = 1'b1;
                    end
                end
            end
            ST_SECOND: begin
                if (expire) store = 1'b1;
            end
            default: cls_d.st = ST_IDLE;
        endcase

        if (store) begin
            if (cls_q.pin) cls_d.res2 = dec_res;
            else           cls_d.res1 = dec_res;
            if (!cls_q.pin && !(cls_q.src && cls_q.vconn)) begin
                cls_d.pin      = 1'b1;
                cls_d.st       = ST_FIRST;
                cls_d.meas_sel = 2'b10;
                cls_d.pu_sel   = cls_q.src ? 2'b10 : 2'b00;
                cls_d.dac      = cls_q.src ? cls_q.thr_open : '0;
                arm            = 1'b1;
            end else begin
                cls_d.st       = ST_IDLE;
                cls_d.done     = 1'b1;
                cls_d.meas_sel = cls_q.saved;
                cls_d.pu_sel   = 2'b00;
                cls_d.dac      = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cls_q <= '0;
        else        cls_q <= cls_d;
    end

    assign meas_sel = cls_q.meas_sel;
    assign pu_sel   = cls_q.pu_sel;
    assign dac_code = cls_q.dac;
    assign cc1_res  = cls_q.res1;
    assign cc2_res  = cls_q.res2;
    assign done     = cls_q.done;

    // During a run exactly one pin is routed to the front end.
    assert_busy_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q.st != ST_IDLE) |-> ($countones(cls_q.meas_sel) == 1));

    // The DAC level holds for the whole settle window.
    assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q.st != ST_IDLE && !expire) |=> $stable(cls_q.dac));

    // With VCONN on, the skipped pin keeps its earlier result.
    assert_keep_cc1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q.st != ST_IDLE && cls_q.src && cls_q.vconn && cls_q.pol)
        |=> $stable(cls_q.res1));
    assert_keep_cc2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q.st != ST_IDLE && cls_q.src && cls_q.vconn && !cls_q.pol)
        |=> $stable(cls_q.res2));

    // Sink runs never close a pull-up switch.
    assert_sink_no_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q.st != ST_IDLE && !cls_q.src) |-> (cls_q.pu_sel == 2'b00));

    // Done is a single-cycle pulse.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cls_q.done |=> !cls_q.done);

    // A start during a run leaves the captured configuration alone.
    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q.st != ST_IDLE && start)
        |=> $stable({cls_q.src, cls_q.vconn, cls_q.pol, cls_q.thr_open, cls_q.thr_rd}));

endmodule

// File: tb/tb_cc_classifier.sv
`timescale 1ns/1ps
module tb_cc_classifier;
    localparam int S  = 6;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          src_role = 1'b0, vconn_on = 1'b0, polarity = 1'b0;
    logic [DW-1:0] thr_open = '0, thr_rd = '0;
    logic [1:0]    idle_sel = 2'b01;
    logic          comp_hi;
    logic [1:0]    level;
    logic [1:0]    meas_sel, pu_sel;
    logic [DW-1:0] dac_code;
    logic [2:0]    cc1_res, cc2_res;
    logic          done;

    logic [DW-1:0] v1 = '0, v2 = '0;
    logic [1:0]    l1 = '0, l2 = '0;

    int  total = 0, bad = 0;
    int  exp1 = 0, exp2 = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    cc_classifier #(.DW(DW), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_role(src_role),
        .vconn_on(vconn_on), .polarity(polarity), .thr_open(thr_open),
        .thr_rd(thr_rd), .idle_sel(idle_sel), .comp_hi(comp_hi), .level(level),
        .meas_sel(meas_sel), .pu_sel(pu_sel), .dac_code(dac_code),
        .cc1_res(cc1_res), .cc2_res(cc2_res), .done(done)
    );

    // Front-end model: each pin has a voltage code and a level code.
    assign comp_hi = (meas_sel == 2'b01) ? (v1 > dac_code) :
                     (meas_sel == 2'b10) ? (v2 > dac_code) : 1'b0;
    assign level   = (meas_sel == 2'b01) ? l1 :
                     (meas_sel == 2'b10) ? l2 : 2'b00;

    task automatic chk(input string req, input string what, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int src_cls(input int v, input int to, input int tr);
        if (v > to) return 0;
        return (v > tr) ? 2 : 1;
    endfunction

    function automatic int snk_cls(input int l);
        return (l == 0) ? 0 : l + 2;
    endfunction

    function automatic int src_time(input int v, input int to);
        return (v > to) ? S : 2 * S;
    endfunction

    task automatic run(input bit src, input bit vc, input bit pol,
                       input int to, input int tr, input int a1, input int a2,
                       input int b1, input int b2, input bit inj, input string tag);
        logic [1:0] saved;
        int T, n, first, fv;
        @(negedge clk);
        src_role = src; vconn_on = vc; polarity = pol;
        thr_open = DW'(to); thr_rd = DW'(tr);
        v1 = DW'(a1); v2 = DW'(a2); l1 = 2'(b1); l2 = 2'(b2);
        saved = idle_sel;
        start = 1'b1;
        T = 0;
        if (src) begin
            if (vc) begin
                if (pol) begin exp2 = src_cls(a2, to, tr); T = src_time(a2, to); end
                else     begin exp1 = src_cls(a1, to, tr); T = src_time(a1, to); end
            end else begin
                exp1 = src_cls(a1, to, tr); exp2 = src_cls(a2, to, tr);
                T = src_time(a1, to) + src_time(a2, to);
            end
        end else begin
            exp1 = snk_cls(b1); exp2 = snk_cls(b2); T = 2 * S;
        end
        first = (src && vc) ? int'(pol) : 0;
        fv    = first ? a2 : a1;
        @(posedge clk); n = 1;
        @(negedge clk);
        start = 1'b0;
        idle_sel = saved ^ 2'b11;
        chk("R2", "first meas_sel", int'(meas_sel), first ? 2 : 1);
        chk(src ? "R2" : "R6", "first dac", int'(dac_code), src ? to : 0);
        chk(src ? "R2" : "R6", "first pu_sel", int'(pu_sel), src ? (first ? 2 : 1) : 0);
        while (!done && n < 1000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (src && fv <= to && n == S + 1)
                chk("R3", "second-step dac", int'(dac_code), tr);
            if (inj && n == 2) begin start = 1'b1; src_role = ~src_role; vconn_on = ~vconn_on; end
            else start = 1'b0;
        end
        chk(inj ? "R9" : "R8", "done latency", n, T + 1);
        chk(tag, "cc1 result", int'(cc1_res), exp1);
        chk(tag, "cc2 result", int'(cc2_res), exp2);
        chk("R7", "restored meas_sel", int'(meas_sel), int'(saved));
        chk("R7", "pu_sel at done", int'(pu_sel), 0);
        @(negedge clk);
        chk("R8", "done low after pulse", int'(done), 0);
        chk("R7", "idle follows idle_sel", int'(meas_sel), int'(idle_sel));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1", "cc1 in reset", int'(cc1_res), 0);
        chk("R1", "cc2 in reset", int'(cc2_res), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "dac in reset", int'(dac_code), 0);
        chk("R1", "meas_sel in reset", int'(meas_sel), 0);
        chk("R1", "pu_sel in reset", int'(pu_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cc1 after reset", int'(cc1_res), 0);
        chk("R7", "meas_sel follows idle", int'(meas_sel), 1);

        // Directed cases
        run(1, 0, 0, 40, 20, 50, 30, 0, 0, 0, "R4");   // open, Rd
        run(1, 0, 0, 40, 20, 10, 25, 0, 0, 0, "R4");   // Ra, Rd
        run(1, 1, 1, 40, 20, 10, 60, 0, 0, 0, "R5");   // CC2 only, CC1 keeps Ra
        run(1, 1, 0, 40, 20, 30, 5, 0, 0, 0, "R5");    // CC1 only, CC2 keeps open
        run(0, 0, 0, 40, 20, 0, 0, 1, 2, 0, "R6");
        run(0, 1, 1, 40, 20, 0, 0, 3, 0, 0, "R6");
        run(1, 0, 0, 40, 20, 40, 20, 0, 0, 0, "R3");   // equal to thresholds
        run(1, 0, 0, 40, 20, 41, 21, 0, 0, 0, "R2");   // just above thresholds
        run(1, 0, 0, 30, 10, 20, 50, 0, 0, 1, "R9");   // start during run
        run(0, 0, 1, 30, 10, 0, 0, 2, 3, 1, "R9");

        // Random cases
        for (int i = 0; i < 40; i++) begin
            bit s, vc, p, inj;
            int to, tr;
            s   = 1'($urandom_range(1, 0));
            vc  = 1'($urandom_range(1, 0));
            p   = 1'($urandom_range(1, 0));
            inj = 1'($urandom_range(1, 0));
            to  = int'($urandom_range(63, 16));
            tr  = int'($urandom_range(15, 0));
            idle_sel = 2'($urandom_range(3, 0));
            run(s, vc, p, to, tr, int'($urandom_range(63, 0)), int'($urandom_range(63, 0)),
                int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), inj,
                s ? (vc ? "R5" : "R4") : "R6");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule